// File: doc/BRIEF.md
# Margining DAC Code Controller

This block is the digital front end for six 8-bit trim DACs that adjust power rails in open loop. Each channel keeps a written code, a two-bit selection of one of four centre ranges (code 0x80 being the middle of the chosen range), and an enable bit. The block presents an effective code, the range selection and an output-enable for every channel to the analog converters and buffers, which lie outside this block. Every output-enable is low after reset, so each analog output stays in high impedance until its channel is enabled.

Two asynchronous board pins can force rail margining. Raising a rail means pulling its feedback node down, so the margin-up pin drives every enabled channel to code 0x00. The margin-down pin drives every enabled channel to code 0xFF. Each pin passes through a two-flop synchronizer into a three-state mode machine. The states are MODE_NORMAL, MODE_UP and MODE_DOWN. The transitions are: NORMAL to UP (up only), NORMAL to DOWN (down asserted), UP to DOWN (down asserted), DOWN to UP (down released while up held), and UP or DOWN back to NORMAL (both released). Margin-down takes precedence in every state.

Writes from the register side always update the stored code. While an override is active, that new code stays hidden behind the forced value. It appears on the output as soon as the mode machine returns to MODE_NORMAL.

Top module: `margin_dac_ctrl`

## Requirements
- R1: After reset, every channel shows code 0x80, range 0 and output-enable 0.
- R2: A write with `wr_en` high and `wr_sel` equal to a channel index (0 to 5) loads that channel's code, range and enable at the clock edge. The new values appear on the outputs after that edge. A write whose `wr_sel` is 6 or 7 changes nothing.
- R3: In MODE_NORMAL, every channel outputs its stored code.
- R4: While only the margin-up pin is held, every enabled channel outputs code 0x00.
- R5: While the margin-down pin is held, every enabled channel outputs code 0xFF.
- R6: When both pins are held, margin-down wins and enabled channels output 0xFF.
- R7: A disabled channel ignores both pins: it keeps its stored code and its output-enable stays 0.
- R8: A code written while an override is active is stored. It appears on the output once both pins are released and the mode machine returns to MODE_NORMAL.
- R9: A change on a margin pin reaches the codes after exactly three rising edges: two synchronizer stages and the mode register. After two edges the codes are unchanged.
- R10: The range output always equals the stored range, whatever the mode.
- R11: Output-enable follows the stored enable bit. It rises only after a write that sets the enable, and it falls after a write that clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| margin_up_in | input | 1 | Asynchronous pin that forces enabled channels to the minimum code |
| margin_dn_in | input | 1 | Asynchronous pin that forces enabled channels to the maximum code; has priority |
| wr_en | input | 1 | Write strobe for one channel |
| wr_sel | input | 3 | Index of the channel to write |
| wr_code | input | 8 | Code to store |
| wr_range | input | 2 | Centre range selection to store |
| wr_enable | input | 1 | Enable bit to store |
| dac_code | output | 48 | Effective codes; channel n occupies bits 8n+7 to 8n |
| dac_range | output | 12 | Range selections; channel n occupies bits 2n+1 to 2n |
| dac_oe | output | 6 | Per-channel output-enable; 0 means high impedance |

## Verification
The bench builds the block with its defaults: six channels, 8-bit codes and two synchronizer stages. With six channels there are only 64 enable masks, so the bench sweeps every mask against all four pin combinations. Before each combination it writes fresh codes and ranges, so every channel is checked in every mode with both enabled and disabled neighbours. The two-stage synchronizer keeps the latency short enough to probe the edge before and the edge after the codes change. Directed cases cover the unused select values and writes made while an override is active.

// File: rtl/margin_pkg.sv
package margin_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_UP     = 2'd1,
        MODE_DOWN   = 2'd2
    } margin_mode_e;

    function automatic logic [7:0] center_code(input int code_w);
        return 8'(1 << (code_w - 1));
    endfunction

endpackage

// File: rtl/margin_sync.sv
module margin_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/margin_mode_fsm.sv
module margin_mode_fsm
    import margin_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_s,
    input  logic         dn_s,
    output margin_mode_e mode_o,
    output logic         force_min,
    output logic         force_max
);
    margin_mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_NORMAL: begin
                if (dn_s)      state_d = MODE_DOWN;
                else if (up_s) state_d = MODE_UP;
            end
            MODE_UP: begin
                if (dn_s)       state_d = MODE_DOWN;
                else if (!up_s) state_d = MODE_NORMAL;
            end
            MODE_DOWN: begin
                if (!dn_s) state_d = up_s ? MODE_UP : MODE_NORMAL;
            end
            default: state_d = MODE_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_NORMAL;
        else        state_q <= state_d;
    end

    always_comb begin
        force_min = 1'b0;
        force_max = 1'b0;
        unique case (state_q)
            MODE_UP:   force_min = 1'b1;
            MODE_DOWN: force_max = 1'b1;
            default:   ;
        endcase
    end

    assign mode_o = state_q;
endmodule

// File: rtl/margin_chan.sv
module margin_chan #(
    parameter int CODE_W  = 8,
    parameter int RANGE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic [CODE_W-1:0]  wr_code,
    input  logic [RANGE_W-1:0] wr_range,
    input  logic               wr_enable,
    input  logic               force_min,
    input  logic               force_max,
    output logic [CODE_W-1:0]  code_o,
    output logic [RANGE_W-1:0] range_o,
    output logic               oe_o
);
    localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);

    logic [CODE_W-1:0]  code_q;
    logic [RANGE_W-1:0] range_q;
    logic               ena_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= CODE_MID;
            range_q <= '0;
            ena_q   <= 1'b0;
        end else if (wr_hit) begin
            code_q  <= wr_code;
            range_q <= wr_range;
            ena_q   <= wr_enable;
        end
    end

    always_comb begin
        if (!ena_q)         code_o = code_q;
        else if (force_max) code_o = '1;
        else if (force_min) code_o = '0;
        else                code_o = code_q;
    end

    assign range_o = range_q;
    assign oe_o    = ena_q;
endmodule

// File: rtl/margin_dac_ctrl.sv
module margin_dac_ctrl
    import margin_pkg::*;
#(
    parameter int NUM_CH      = 6,
    parameter int CODE_W      = 8,
    parameter int RANGE_W     = 2,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      margin_up_in,
    input  logic                      margin_dn_in,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_sel,
    input  logic [CODE_W-1:0]         wr_code,
    input  logic [RANGE_W-1:0]        wr_range,
    input  logic                      wr_enable,
    output logic [NUM_CH*CODE_W-1:0]  dac_code,
    output logic [NUM_CH*RANGE_W-1:0] dac_range,
    output logic [NUM_CH-1:0]         dac_oe
);
    logic [1:0]   pins_sync;
    logic         up_sync, dn_sync;
    logic         force_min, force_max;
    margin_mode_e mode_cur;

    margin_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({margin_dn_in, margin_up_in}),
        .q     (pins_sync)
    );

    assign up_sync = pins_sync[0];
    assign dn_sync = pins_sync[1];

    margin_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .up_s      (up_sync),
        .dn_s      (dn_sync),
        .mode_o    (mode_cur),
        .force_min (force_min),
        .force_max (force_max)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = wr_en && (wr_sel == SEL_W'(i));

        margin_chan #(.CODE_W(CODE_W), .RANGE_W(RANGE_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hit    (hit),
            .wr_code   (wr_code),
            .wr_range  (wr_range),
            .wr_enable (wr_enable),
            .force_min (force_min),
            .force_max (force_max),
            .code_o    (dac_code[i*CODE_W +: CODE_W]),
            .range_o   (dac_range[i*RANGE_W +: RANGE_W]),
            .oe_o      (dac_oe[i])
        );
    end
endmodule

// File: rtl/margin_dac_ctrl_chk.sv
module margin_dac_ctrl_chk #(
    parameter int NUM_CH = 6,
    parameter int CODE_W = 8,
    parameter int SEL_W  = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     up_s,
    input logic                     dn_s,
    input logic [1:0]               mode,
    input logic                     wr_en,
    input logic [SEL_W-1:0]         wr_sel,
    input logic                     wr_enable,
    input logic [NUM_CH*CODE_W-1:0] dac_code,
    input logic [NUM_CH-1:0]        dac_oe
);
    localparam logic [1:0] M_NORMAL = 2'd0;
    localparam logic [1:0] M_UP     = 2'd1;
    localparam logic [1:0] M_DOWN   = 2'd2;

    AST_DOWN_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        dn_s |=> mode == M_DOWN); // R6

    AST_UP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (up_s && !dn_s) |=> mode == M_UP); // R4

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_s && !dn_s) |=> mode == M_NORMAL); // R8

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ast
        AST_FORCE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == M_DOWN && dac_oe[i]) |-> dac_code[i*CODE_W +: CODE_W] == '1); // R5

        AST_FORCE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == M_UP && dac_oe[i]) |-> dac_code[i*CODE_W +: CODE_W] == '0); // R4

        AST_OE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dac_oe[i]) |-> $past(wr_en && wr_sel == SEL_W'(i) && wr_enable)); // R11

        AST_OE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(dac_oe[i]) |-> $past(wr_en && wr_sel == SEL_W'(i) && !wr_enable)); // R11

        AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            (!dac_oe[i] && !$past(wr_en && wr_sel == SEL_W'(i)))
                |-> $stable(dac_code[i*CODE_W +: CODE_W])); // R7
    end
endmodule

bind margin_dac_ctrl margin_dac_ctrl_chk #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W),
    .SEL_W  (SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_s      (up_sync),
    .dn_s      (dn_sync),
    .mode      (mode_cur),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_enable (wr_enable),
    .dac_code  (dac_code),
    .dac_oe    (dac_oe)
);

// File: tb/margin_dac_ctrl_test.sv
`timescale 1ns/1ps
module margin_dac_ctrl_test;
    localparam int NUM_CH  = 6;
    localparam int CODE_W  = 8;
    localparam int RANGE_W = 2;
    localparam int SEL_W   = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                      rst_n;
    logic                      margin_up_in, margin_dn_in;
    logic                      wr_en;
    logic [SEL_W-1:0]          wr_sel;
    logic [CODE_W-1:0]         wr_code;
    logic [RANGE_W-1:0]        wr_range;
    logic                      wr_enable;
    logic [NUM_CH*CODE_W-1:0]  dac_code;
    logic [NUM_CH*RANGE_W-1:0] dac_range;
    logic [NUM_CH-1:0]         dac_oe;

    margin_dac_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .margin_up_in(margin_up_in), .margin_dn_in(margin_dn_in),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_code(wr_code),
        .wr_range(wr_range), .wr_enable(wr_enable),
        .dac_code(dac_code), .dac_range(dac_range), .dac_oe(dac_oe)
    );

    int vectors = 0;
    int miscompares = 0;

    logic [7:0] m_code [NUM_CH];
    logic [1:0] m_rng  [NUM_CH];
    logic       m_en   [NUM_CH];

    function automatic logic [7:0] exp_code(int ch, logic up, logic dn);
        if (!m_en[ch]) return m_code[ch];
        if (dn)        return 8'hFF;
        if (up)        return 8'h00;
        return m_code[ch];
    endfunction

    task automatic check_all(string req, logic up, logic dn);
        for (int ch = 0; ch < NUM_CH; ch++) begin
            logic [7:0] ec, gc;
            logic [1:0] gr;
            ec = exp_code(ch, up, dn);
            gc = dac_code[ch*CODE_W +: CODE_W];
            gr = dac_range[ch*RANGE_W +: RANGE_W];
            vectors++;
            if (gc !== ec || gr !== m_rng[ch] || dac_oe[ch] !== m_en[ch]) begin
                miscompares++;
                $display("FAIL %s ch%0d code/range/oe got %h/%0d/%b exp %h/%0d/%b",
                         req, ch, gc, gr, dac_oe[ch], ec, m_rng[ch], m_en[ch]);
            end
        end
    endtask

    // called at a negedge; leaves the bench at the following negedge
    task automatic do_write(int sel, logic [7:0] code, logic [1:0] rng, logic en);
        wr_en = 1'b1; wr_sel = SEL_W'(sel); wr_code = code;
        wr_range = rng; wr_enable = en;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        if (sel < NUM_CH) begin
            m_code[sel] = code; m_rng[sel] = rng; m_en[sel] = en;
        end
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 1'b0; margin_up_in = 1'b0; margin_dn_in = 1'b0;
        wr_en = 1'b0; wr_sel = '0; wr_code = '0; wr_range = '0; wr_enable = 1'b0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            m_code[ch] = 8'h80; m_rng[ch] = 2'd0; m_en[ch] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset", 1'b0, 1'b0);

        // R7: pins on disabled channels have no effect
        margin_dn_in = 1'b1; settle();
        check_all("R7 disabled ignores down", 1'b0, 1'b1);
        margin_dn_in = 1'b0; margin_up_in = 1'b1; settle();
        check_all("R7 disabled ignores up", 1'b1, 1'b0);
        margin_up_in = 1'b0; settle();

        // R2: select values past the last channel are ignored
        do_write(6, 8'h11, 2'd3, 1'b1);
        check_all("R2 sel6 ignored", 1'b0, 1'b0);
        do_write(7, 8'h22, 2'd2, 1'b1);
        check_all("R2 sel7 ignored", 1'b0, 1'b0);

        // R2 R3 R11: each write visible immediately
        for (int ch = 0; ch < NUM_CH; ch++) begin
            do_write(ch, 8'(ch * 41 + 5), 2'(ch), 1'b1);
            check_all("R2 R3 R11 write", 1'b0, 1'b0);
        end

        // R9: latency of exactly three edges
        margin_dn_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_all("R9 unchanged after two edges", 1'b0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check_all("R9 R5 forced after three edges", 1'b0, 1'b1);

        // R8: writes during an override are held
        do_write(2, 8'h3C, 2'd1, 1'b1);
        check_all("R8 held during down", 1'b0, 1'b1);
        margin_dn_in = 1'b0; settle();
        check_all("R8 applied after release", 1'b0, 1'b0);
        margin_up_in = 1'b1; settle();
        do_write(4, 8'hA7, 2'd2, 1'b1);
        check_all("R8 held during up", 1'b1, 1'b0);
        margin_up_in = 1'b0; settle();
        check_all("R8 applied after up release", 1'b0, 1'b0);

        // R11: clearing enable drops oe
        do_write(1, 8'h55, 2'd3, 1'b0);
        check_all("R11 oe cleared", 1'b0, 1'b0);

        // Sweep: all enable masks against all pin combinations
        for (int mask = 0; mask < (1 << NUM_CH); mask++) begin
            for (int pins = 0; pins < 4; pins++) begin
                for (int ch = 0; ch < NUM_CH; ch++)
                    do_write(ch, 8'(ch * 29 + mask * 7 + pins * 13 + 3),
                             2'(ch + mask + pins), mask[ch]);
                check_all("R3 R11 sweep normal", 1'b0, 1'b0);
                margin_up_in = pins[0];
                margin_dn_in = pins[1];
                settle();
                // R4 up-only, R5 down, R6 both, R7 disabled, R10 range
                check_all("R4 R5 R6 R7 R10 sweep forced", pins[0], pins[1]);
                margin_up_in = 1'b0;
                margin_dn_in = 1'b0;
                settle();
                check_all("R3 R8 sweep release", 1'b0, 1'b0);
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule